// File: doc/BRIEF.md
# Line and Rectangle Fill Engine

This block draws horizontal lines, vertical lines and solid rectangles into a packed frame store held in a shared static RAM. A small CPU loads two corner points, a 3-bit colour and a target page through byte-wide register writes. A write to the command register then launches the operation. The engine walks the covered area on its own. It raises a request to the memory arbiter and moves forward only on cycles in which the arbiter grants the bus. The video fetch can therefore take the memory at any time without the drawing losing its place. The CPU sees only a busy flag, which falls once the last byte has been written.

Each byte of the frame store holds two pixels. The engine writes a whole byte when both of its pixels lie inside the span. At a span edge that covers only one pixel of a byte, it reads the byte and writes it back with that one pixel changed. Coordinates beyond the visible area are clamped to the edge. Corners given in reverse order are swapped.

Top module: `draw_engine`

## Requirements
- R1: After reset `busy` and `mem_req` are low. The register index map is: 0/1 X0 low byte/high bits[1:0], 2/3 Y0 low/high, 4/5 X1 low/high, 6/7 Y1 low/high, 8 colour bits[2:0], 9 page bits[2:0], 10 command. Writing 8'h01 (horizontal line), 8'h02 (vertical line) or 8'h03 (rectangle) to index 10 while idle raises `busy` in the next cycle. Any other command value starts nothing.
- R2: Register writes, including command writes, that arrive while `busy` is high are ignored. A later operation uses the values held before that write.
- R3: The byte address is page*2^18 + y*320 + x/2. An even x lives in byte bits [2:0] and an odd x in bits [6:4].
- R4: When x is even and x+1 is also inside the span, the engine makes one write of {1'b0,colour,1'b0,colour} to that byte, with no read.
- R5: A byte in which only one pixel is covered is read (`mem_we`=0). Then it is written at the same address with the covered pixel's nibble set to {1'b0,colour} and the other nibble copied unchanged from the read data.
- R6: Bytes are visited row by row from the top row to the bottom row, and left to right within a row.
- R7: A request holds its address, write enable and write data unchanged until `mem_gnt` is seen high. An access completes in the cycle where `mem_req` and `mem_gnt` are both high, and read data is taken from `mem_rdata` in that cycle.
- R8: X coordinates above 639 are treated as 639, and Y coordinates above 479 are treated as 479.
- R9: If the second corner is left of or above the first, the two values are swapped on that axis.
- R10: `busy` is low in the cycle right after the clock edge that accepts the final write. `mem_req` is never high while `busy` is low.
- R11: A horizontal line uses rows Y0 only, ignoring Y1. A vertical line uses column X0 only, ignoring X1. A rectangle uses both corners.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | CPU register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_gnt | input | 1 | Arbiter grant; the access completes when high with mem_req |
| mem_addr | output | 21 | Byte address: page and offset |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the granted read cycle |

## Verification
Shapes are chosen to split the two write styles. One rectangle has an odd left edge and an even right edge, so each row mixes whole-byte writes with read-modify-writes at both ends. Single-pixel and single-byte rectangles separate an even pixel at the span end from a full pair. Reversed corners and off-screen values check the swap and the clamp. Horizontal and vertical lines carry deliberately unrelated second coordinates, which shows that those values are ignored. Each shape runs under a different grant pattern: always granted, roughly half, and sparse. A freeze on a lost grant is told apart from skipped progress, because the bench memory seeds every byte with a value that depends on its address and checks the exact order of accesses.

// File: rtl/draw_pkg.sv
`timescale 1ns/1ps
package draw_pkg;
    localparam int COORD_W   = 10;
    localparam int COL_W     = 3;
    localparam int PAGE_W    = 3;
    localparam int OFF_W     = 18;
    localparam int ADDR_W    = PAGE_W + OFF_W;
    localparam int REG_IDX_W = 4;

    typedef logic [COORD_W-1:0] coord_t;

    typedef enum logic [REG_IDX_W-1:0] {
        RI_X0_LO  = 4'd0,
        RI_X0_HI  = 4'd1,
        RI_Y0_LO  = 4'd2,
        RI_Y0_HI  = 4'd3,
        RI_X1_LO  = 4'd4,
        RI_X1_HI  = 4'd5,
        RI_Y1_LO  = 4'd6,
        RI_Y1_HI  = 4'd7,
        RI_COLOUR = 4'd8,
        RI_PAGE   = 4'd9,
        RI_CMD    = 4'd10
    } reg_idx_e;

    typedef enum logic [7:0] {
        OP_HLINE = 8'h01,
        OP_VLINE = 8'h02,
        OP_RECT  = 8'h03
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPAN,
        ST_MERGE
    } seq_st_e;

    typedef struct packed {
        coord_t             xl;
        coord_t             xr;
        coord_t             yt;
        coord_t             yb;
        logic [COL_W-1:0]   col;
        logic [PAGE_W-1:0]  page;
    } job_t;

    function automatic coord_t clip_coord(coord_t v, coord_t lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic logic [7:0] fill_byte(logic [COL_W-1:0] col);
        return {1'b0, col, 1'b0, col};
    endfunction

    function automatic logic [7:0] merge_byte(logic [7:0] old, logic [COL_W-1:0] col, logic odd);
        return odd ? {1'b0, col, old[3:0]} : {old[7:4], 1'b0, col};
    endfunction

    function automatic logic [ADDR_W-1:0] byte_addr(logic [PAGE_W-1:0] pg, coord_t x, coord_t y, int stride);
        logic [OFF_W-1:0] off;
        off = OFF_W'(y) * OFF_W'(stride) + OFF_W'(x >> 1);
        return {pg, off};
    endfunction
endpackage

// File: rtl/draw_regs.sv
`timescale 1ns/1ps
module draw_regs
    import draw_pkg::*;
#(
    parameter int HRES = 640,
    parameter int VRES = 480
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 busy,
    output logic                 start,
    output job_t                 job
);
    localparam int     HI_W  = COORD_W - 8;
    localparam coord_t LIM_X = coord_t'(HRES - 1);
    localparam coord_t LIM_Y = coord_t'(VRES - 1);

    coord_t x0_q, y0_q, x1_q, y1_q;
    logic [COL_W-1:0]  col_q;
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x0_q   <= '0;
            y0_q   <= '0;
            x1_q   <= '0;
            y1_q   <= '0;
            col_q  <= '0;
            page_q <= '0;
        end else if (wr_en && !busy) begin
            case (reg_idx_e'(wr_idx))
                RI_X0_LO:  x0_q[7:0]         <= wr_data;
                RI_X0_HI:  x0_q[COORD_W-1:8] <= wr_data[HI_W-1:0];
                RI_Y0_LO:  y0_q[7:0]         <= wr_data;
                RI_Y0_HI:  y0_q[COORD_W-1:8] <= wr_data[HI_W-1:0];
                RI_X1_LO:  x1_q[7:0]         <= wr_data;
                RI_X1_HI:  x1_q[COORD_W-1:8] <= wr_data[HI_W-1:0];
                RI_Y1_LO:  y1_q[7:0]         <= wr_data;
                RI_Y1_HI:  y1_q[COORD_W-1:8] <= wr_data[HI_W-1:0];
                RI_COLOUR: col_q             <= wr_data[COL_W-1:0];
                RI_PAGE:   page_q            <= wr_data[PAGE_W-1:0];
                default:   ;
            endcase
        end
    end

    logic op_ok;
    assign op_ok = (wr_data == OP_HLINE) || (wr_data == OP_VLINE) || (wr_data == OP_RECT);
    assign start = wr_en && !busy && (wr_idx == RI_CMD) && op_ok;

    // Clamp first, then pick the shape's corners, then order each axis.
    coord_t cx0, cy0, cx1, cy1, ax, bx, ay, by;
    always_comb begin
        cx0 = clip_coord(x0_q, LIM_X);
        cx1 = clip_coord(x1_q, LIM_X);
        cy0 = clip_coord(y0_q, LIM_Y);
        cy1 = clip_coord(y1_q, LIM_Y);
        ax  = cx0;
        bx  = cx1;
        ay  = cy0;
        by  = cy1;
        if (wr_data == OP_HLINE) by = cy0;
        else if (wr_data == OP_VLINE) bx = cx0;
        job.xl   = (ax <= bx) ? ax : bx;
        job.xr   = (ax <= bx) ? bx : ax;
        job.yt   = (ay <= by) ? ay : by;
        job.yb   = (ay <= by) ? by : ay;
        job.col  = col_q;
        job.page = page_q;
    end

    AST_LOCKED_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable({x0_q, y0_q, x1_q, y1_q, col_q, page_q})); // R2
endmodule

// File: rtl/draw_pack.sv
`timescale 1ns/1ps
module draw_pack
    import draw_pkg::*;
#(
    parameter int HRES = 640
) (
    input  logic [PAGE_W-1:0] page,
    input  coord_t            cur_x,
    input  coord_t            cur_y,
    input  logic [COL_W-1:0]  col,
    input  logic [7:0]        old_byte,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        full_data,
    output logic [7:0]        merge_data
);
    localparam int STRIDE = HRES / 2;

    assign addr       = byte_addr(page, cur_x, cur_y, STRIDE);
    assign full_data  = fill_byte(col);
    assign merge_data = merge_byte(old_byte, col, cur_x[0]);
endmodule

// File: rtl/draw_seq.sv
`timescale 1ns/1ps
module draw_seq
    import draw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  job_t              job,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              full_sel,
    output coord_t            cur_x,
    output coord_t            cur_y,
    output logic [COL_W-1:0]  cur_col,
    output logic [PAGE_W-1:0] cur_page,
    output logic [7:0]        old_byte
);
    seq_st_e st_q;
    job_t    job_q;
    coord_t  cx_q, cy_q;
    logic [7:0] rd_q;

    logic               full, adv, row_end, last;
    logic [COORD_W:0]   nx;

    assign full    = !cx_q[0] && (cx_q != job_q.xr);
    assign nx      = {1'b0, cx_q} + (COORD_W+1)'(full ? 2 : 1);
    assign row_end = nx > {1'b0, job_q.xr};
    assign last    = row_end && (cy_q == job_q.yb);
    assign adv     = mem_gnt && (((st_q == ST_SPAN) && full) || (st_q == ST_MERGE));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE:  if (start) st_q <= ST_SPAN;
                ST_SPAN:  if (mem_gnt) begin
                              if (!full)     st_q <= ST_MERGE;
                              else if (last) st_q <= ST_IDLE;
                          end
                ST_MERGE: if (mem_gnt) st_q <= last ? ST_IDLE : ST_SPAN;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q <= '0;
            cx_q  <= '0;
            cy_q  <= '0;
            rd_q  <= '0;
        end else begin
            if ((st_q == ST_IDLE) && start) begin
                job_q <= job;
                cx_q  <= job.xl;
                cy_q  <= job.yt;
            end else if (adv) begin
                if (row_end) begin
                    cx_q <= job_q.xl;
                    if (!last) cy_q <= cy_q + coord_t'(1);
                end else begin
                    cx_q <= nx[COORD_W-1:0];
                end
            end
            if ((st_q == ST_SPAN) && mem_gnt && !full) rd_q <= mem_rdata;
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign mem_req  = busy;
    assign mem_we   = ((st_q == ST_SPAN) && full) || (st_q == ST_MERGE);
    assign full_sel = (st_q == ST_SPAN);
    assign cur_x    = cx_q;
    assign cur_y    = cy_q;
    assign cur_col  = job_q.col;
    assign cur_page = job_q.page;
    assign old_byte = rd_q;

    AST_ROW_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cur_y >= $past(cur_y))); // R6
    AST_CURSOR_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cur_x >= job_q.xl && cur_x <= job_q.xr)); // R9
endmodule

// File: rtl/draw_engine.sv
`timescale 1ns/1ps
module draw_engine
    import draw_pkg::*;
#(
    parameter int HRES = 640,
    parameter int VRES = 480
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [7:0]           reg_wdata,
    output logic                 busy,
    output logic                 mem_req,
    output logic                 mem_we,
    input  logic                 mem_gnt,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic [7:0]           mem_rdata
);
    localparam int PAGE_BYTES = HRES * VRES / 2;

    logic              start, full_sel;
    job_t              job;
    coord_t            cur_x, cur_y;
    logic [COL_W-1:0]  cur_col;
    logic [PAGE_W-1:0] cur_page;
    logic [7:0]        old_byte, full_data, merge_data;

    draw_regs #(.HRES(HRES), .VRES(VRES)) regs_i (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_idx(reg_idx),
        .wr_data(reg_wdata), .busy(busy), .start(start), .job(job)
    );

    draw_seq seq_i (
        .clk(clk), .rst(rst), .start(start), .job(job),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .full_sel(full_sel),
        .cur_x(cur_x), .cur_y(cur_y), .cur_col(cur_col),
        .cur_page(cur_page), .old_byte(old_byte)
    );

    draw_pack #(.HRES(HRES)) pack_i (
        .page(cur_page), .cur_x(cur_x), .cur_y(cur_y), .col(cur_col),
        .old_byte(old_byte), .addr(mem_addr),
        .full_data(full_data), .merge_data(merge_data)
    );

    assign mem_wdata = full_sel ? full_data : merge_data;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !busy && reg_idx == RI_CMD && reg_wdata == OP_RECT) |=> busy); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R7
    AST_RMW_PAIR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_gnt) |=> (mem_req && mem_we && mem_addr == $past(mem_addr))); // R5
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R10
    AST_ADDR_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (int'(mem_addr[OFF_W-1:0]) < PAGE_BYTES)); // R8
endmodule

// File: tb/draw_engine_tb.sv
`timescale 1ns/1ps
module draw_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic        busy, mem_req, mem_we;
    logic        mem_gnt = 1'b0;
    logic [20:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    draw_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic        we;
        logic        full;
        logic        odd;
        logic [2:0]  col;
        logic [20:0] addr;
    } acc_t;

    acc_t       expq[$];
    logic [7:0] vmem [int];
    int    n_chk = 0, n_fail = 0, cyc = 0, gmode = 0;
    logic [15:0] lfsr = 16'hACE1;
    string tag = "R1";
    int sx0 = 0, sy0 = 0, sx1 = 0, sy1 = 0, scol = 0, spage = 0;

    function automatic logic [7:0] peek(int a);
        if (vmem.exists(a)) return vmem[a];
        return 8'(a ^ (a >> 8) ^ 8'h5A);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int clipv(int v, int lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic acc_t mk(bit we, bit full, bit odd, int x, int y);
        acc_t e;
        e.we = we; e.full = full; e.odd = odd; e.col = 3'(scol);
        e.addr = 21'(spage * 262144 + y * 320 + x / 2);
        return e;
    endfunction

    // Expected access stream from R3..R6, R8, R9, R11
    task automatic build(int op);
        int ax, bx, ay, by, xl, xr, yt, yb;
        ax = clipv(sx0, 639); bx = clipv(sx1, 639);
        ay = clipv(sy0, 479); by = clipv(sy1, 479);
        if (op == 1) by = ay;
        if (op == 2) bx = ax;
        xl = (ax < bx) ? ax : bx; xr = (ax < bx) ? bx : ax;
        yt = (ay < by) ? ay : by; yb = (ay < by) ? by : ay;
        for (int y = yt; y <= yb; y++) begin
            int x = xl;
            while (x <= xr) begin
                if ((x % 2 == 0) && (x < xr)) begin
                    expq.push_back(mk(1, 1, 0, x, y));
                    x += 2;
                end else begin
                    expq.push_back(mk(0, 0, x % 2 == 1, x, y));
                    expq.push_back(mk(1, 0, x % 2 == 1, x, y));
                    x += 1;
                end
            end
        end
    endtask

    always @(negedge clk) begin
        acc_t e;
        logic [7:0] m, ed;
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (gmode == 0) mem_gnt = 1'b1;
        else if (gmode == 1) mem_gnt = lfsr[0];
        else mem_gnt = lfsr[0] & lfsr[4];
        mem_rdata = peek(int'(mem_addr));
        #1;
        if (!rst) begin
            chk(busy === (expq.size() != 0), "R10", "busy", int'(busy), int'(expq.size() != 0));
            if (mem_req) begin
                if (expq.size() == 0) begin
                    chk(0, "R10", "request while idle", 1, 0);
                end else begin
                    e = expq[0];
                    chk(mem_addr === e.addr, $sformatf("%s R3 R6 R7", tag), "addr", int'(mem_addr), int'(e.addr));
                    chk(mem_we === e.we, $sformatf("%s R4 R5", tag), "we", int'(mem_we), int'(e.we));
                    if (mem_gnt) begin
                        if (e.we) begin
                            m = peek(int'(e.addr));
                            if (e.full) ed = {1'b0, e.col, 1'b0, e.col};
                            else ed = e.odd ? {1'b0, e.col, m[3:0]} : {m[7:4], 1'b0, e.col};
                            chk(mem_wdata === ed, e.full ? "R4" : "R5", "wdata", int'(mem_wdata), int'(ed));
                            vmem[int'(e.addr)] = ed;
                        end
                        void'(expq.pop_front());
                    end
                end
            end
        end
        if (cyc == 150000) begin
            chk(0, "R10", "watchdog expired", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic cpu_wr(int idx, int data);
        bit was_busy;
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 4'(idx); reg_wdata = 8'(data);
        was_busy = busy;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        if (!was_busy) begin
            case (idx)
                0: sx0 = (sx0 & 32'h300) | (data & 255);
                1: sx0 = (sx0 & 255) | ((data & 3) << 8);
                2: sy0 = (sy0 & 32'h300) | (data & 255);
                3: sy0 = (sy0 & 255) | ((data & 3) << 8);
                4: sx1 = (sx1 & 32'h300) | (data & 255);
                5: sx1 = (sx1 & 255) | ((data & 3) << 8);
                6: sy1 = (sy1 & 32'h300) | (data & 255);
                7: sy1 = (sy1 & 255) | ((data & 3) << 8);
                8: scol = data & 7;
                9: spage = data & 7;
                10: if (data >= 1 && data <= 3) build(data);
                default: ;
            endcase
        end
    endtask

    task automatic setall(int x0, int y0, int x1, int y1, int col, int pg);
        cpu_wr(0, x0 & 255); cpu_wr(1, x0 >> 8);
        cpu_wr(2, y0 & 255); cpu_wr(3, y0 >> 8);
        cpu_wr(4, x1 & 255); cpu_wr(5, x1 >> 8);
        cpu_wr(6, y1 & 255); cpu_wr(7, y1 >> 8);
        cpu_wr(8, col); cpu_wr(9, pg);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            #2;
            if (expq.size() == 0 && !busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #2;
        chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(mem_req === 1'b0, "R1", "req after reset", int'(mem_req), 0);

        // R6: rectangle with odd left and even right edge, full grant
        tag = "R6"; gmode = 0;
        setall(3, 2, 8, 4, 5, 1); cpu_wr(10, 3); wait_idle();

        // R9 R11: reversed horizontal line, Y1 ignored, grant ~50%
        tag = "R9 R11"; gmode = 1;
        setall(10, 7, 1, 300, 2, 0); cpu_wr(10, 1); wait_idle();

        // R8 R11: vertical line clamped in Y and swapped, X1 ignored, sparse grant
        tag = "R8 R11"; gmode = 2;
        setall(5, 600, 900, 475, 6, 7); cpu_wr(10, 2); wait_idle();

        // R8: horizontal line clamped in X
        tag = "R8"; gmode = 1;
        setall(1000, 479, 636, 0, 3, 2); cpu_wr(10, 1); wait_idle();

        // R1: invalid command values start nothing
        tag = "R1";
        cpu_wr(10, 0); cpu_wr(10, 8'h07);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #2;
            chk(busy === 1'b0, "R1", "busy after invalid command", int'(busy), 0);
        end

        // R2: writes during an operation are dropped
        tag = "R2"; gmode = 1;
        setall(0, 10, 40, 20, 1, 3); cpu_wr(10, 3);
        cpu_wr(0, 200); cpu_wr(8, 7); cpu_wr(10, 3);
        wait_idle();
        cpu_wr(10, 1); wait_idle();

        // R4 R5: single even pixel, then one full pair
        tag = "R4 R5"; gmode = 0;
        setall(4, 9, 4, 9, 4, 0); cpu_wr(10, 3); wait_idle();
        setall(6, 9, 7, 9, 6, 0); cpu_wr(10, 3); wait_idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule